// File: doc/BRIEF.md
# Simplified I2C-Compatible Serial Byte Engine

This block moves one byte at a time over a two-wire open-drain bus in a simplified I2C-compatible manner. As a bus master it makes SCL from an internal divider. As a slave it takes its bit timing from the external SCL. Both wires are modelled as open-drain: the block only ever pulls a line low (`*_oe` high) or releases it, and it reads the resolved level back through `scl_in` and `sda_in`. Every frame carries eight data bits, most significant bit first, followed by one acknowledge bit.

A frame begins only when transmit is enabled and the transmit buffer holds a byte. Reception uses the same rule, because a receiving block still clocks out a dummy byte of all ones. In receive mode the block drives the acknowledge low and stores the byte, and it flags an overrun if the previous byte was never read. In transmit mode the block releases the acknowledge bit and reports whether the far end pulled it low. A released data bit that reads back low means arbitration has been lost; the block then lets go of SDA for the rest of the frame.

Start and stop conditions are recognised on the synchronised lines. New SDA values are applied only after SCL has been seen low, with a selectable extra lag of 2 to 8 clock cycles. An optional clock-phase setting stretches the first SCL high time in master mode.

Top module: `i2cs_engine`

## Requirements
- R1: In master mode each SCL low and high phase lasts `div_n`+1 clock cycles, so one SCL period is 2*(`div_n`+1) cycles.
- R2: Data goes out MSB first. Bit k (k=0 is the MSB) is valid on SDA at SCL rising edge k+1, and the ninth rising edge carries the acknowledge.
- R3: A frame starts only when `tx_en`=1 and `tx_full`=1. Setting `rx_en` alone starts nothing. `tx_wr` sets `tx_full`, and the start of a frame clears it.
- R4: SDA changes only while SCL is low. The change comes 3 cycles after the SCL line falls when `lag_sel`=0, and `lag_sel`+4 cycles after it when `lag_sel` is 1 to 7 (an added lag of 2 to 8 cycles).
- R5: In master mode, `clk_phase`=1 delays the first SCL fall by `div_n`+1 cycles compared with `clk_phase`=0.
- R6: SDA falling while SCL stays high gives one `ev_start` pulse. SDA rising while SCL stays high gives one `ev_stop` pulse.
- R7: With `rx_en`=0 the block releases SDA in the ninth bit. A low sample there gives one `ev_ack` pulse, and a high sample gives one `ev_nack` pulse.
- R8: With `rx_en`=1 the block drives the ninth bit low. On the eighth rising edge it stores the byte in `rx_data`, sets `rx_full` and pulses `rx_done`.
- R9: If a byte completes while `rx_full`=1 and `rx_rd`=0, `overrun` is set and neither `rx_done` nor `rx_full` changes. `rx_rd` clears `rx_full` and `overrun`. An `rx_rd` in the cycle of completion counts as a read before the store: the byte is stored, `rx_done` pulses and no overrun is flagged.
- R10: With `rx_en`=0, a released data bit that samples low sets arbitration loss, and SDA stays released for the rest of the frame. `arb_lost` is set at that rising edge when `abt_sel`=0, and at the end of the frame when `abt_sel`=1. It is cleared when the next frame starts.
- R11: With `master`=0 the block never pulls SCL, and bits follow the edges on `scl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count source for the divider and the SDA lag |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = generate SCL internally, 0 = follow external SCL |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable (drive acknowledge, store byte) |
| abt_sel | input | 1 | 0 = arbitration flag at the losing bit, 1 = at frame end |
| clk_phase | input | 1 | 1 = stretch the first SCL high phase |
| div_n | input | DIV_W | Divider setting n |
| lag_sel | input | 3 | SDA lag select: 0 none, k gives k+1 cycles |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | DW | Byte to send |
| rx_rd | input | 1 | Read strobe for the receive buffer |
| rx_data | output | DW | Last stored received byte |
| tx_full | output | 1 | Transmit buffer holds a byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| rx_done | output | 1 | One-cycle pulse when a byte is stored |
| overrun | output | 1 | A byte completed while the buffer was unread |
| arb_lost | output | 1 | Arbitration lost in the current or last frame |
| busy | output | 1 | A frame or the master clock sequence is in progress |
| ev_start | output | 1 | Start condition pulse |
| ev_stop | output | 1 | Stop condition pulse |
| ev_ack | output | 1 | Acknowledge sampled low |
| ev_nack | output | 1 | Acknowledge sampled high |
| scl_in | input | 1 | Resolved SCL line level |
| scl_oe | output | 1 | 1 = pull SCL low |
| sda_in | input | 1 | Resolved SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |

## Verification
A host read and the completion of a new byte can land in the same clock cycle. The bench provokes this by counting rising SCL edges on the line during a second receive frame, then asserting `rx_rd` exactly in the cycle the synchronised eighth edge is processed, two cycles after the line rises. It judges the outcome at the ports: `overrun` must stay clear, `rx_data` must hold the new byte, and the `rx_done` pulse count must rise by one. A separate frame left unread shows the contrasting case, where `overrun` is set and no pulse appears.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  // number of clock cycles in one SCL phase for divider setting n
  function automatic int phase_cycles(input int n);
    return n + 1;
  endfunction

  // extra SDA lag in clock cycles for a lag select code
  function automatic logic [3:0] lag_cycles(input logic [2:0] sel);
    return (sel == 3'd0) ? 4'd0 : ({1'b0, sel} + 4'd1);
  endfunction
endpackage

// File: rtl/i2cs_baud.sv
module i2cs_baud #(
  parameter int DIV_W   = 8,
  parameter int HP_LAST = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             phase,
  input  logic [DIV_W-1:0] div_n,
  output logic             run,
  output logic             scl_low
);
  localparam int HPW = $clog2(HP_LAST + 1);

  logic [DIV_W-1:0] cnt;
  logic [HPW-1:0]   hp;

  // hp 0: optional stretched high, odd: low phases, even: high phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
      hp  <= '0;
    end else if (go) begin
      run <= 1'b1;
      cnt <= '0;
      hp  <= phase ? HPW'(0) : HPW'(1);
    end else if (run) begin
      if (cnt == div_n) begin
        cnt <= '0;
        if (hp == HPW'(HP_LAST)) run <= 1'b0;
        else                     hp  <= hp + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign scl_low = run & hp[0];
endmodule

// File: rtl/i2cs_linewatch.sv
module i2cs_linewatch (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_in};
      sda_p <= {sda_p[1:0], sda_in};
    end
  end

  assign sda_s     = sda_p[1];
  assign scl_rise  = scl_p[1] & ~scl_p[2];
  assign scl_fall  = ~scl_p[1] & scl_p[2];
  assign start_det = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  assign stop_det  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
endmodule

// File: rtl/i2cs_sdalag.sv
module i2cs_sdalag (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       val,
  input  logic [2:0] sel,
  output logic       rel
);
  import i2cs_pkg::*;

  logic [3:0] left;
  logic       pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel  <= 1'b1;
      pend <= 1'b1;
      left <= '0;
    end else if (load) begin
      if (lag_cycles(sel) == 4'd0) begin
        rel <= val;
      end else begin
        pend <= val;
        left <= lag_cycles(sel);
      end
    end else if (left != 4'd0) begin
      left <= left - 1'b1;
      if (left == 4'd1) rel <= pend;
    end
  end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine #(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             abt_sel,
  input  logic             clk_phase,
  input  logic [DIV_W-1:0] div_n,
  input  logic [2:0]       lag_sel,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_data,
  output logic             tx_full,
  output logic             rx_full,
  output logic             rx_done,
  output logic             overrun,
  output logic             arb_lost,
  output logic             busy,
  output logic             ev_start,
  output logic             ev_stop,
  output logic             ev_ack,
  output logic             ev_nack,
  input  logic             scl_in,
  output logic             scl_oe,
  input  logic             sda_in,
  output logic             sda_oe
);
  localparam int CW      = $clog2(DW + 2);
  localparam int HP_LAST = 2 * DW + 3;

  logic          active, cur_bit, arb_hit, drv;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] tx_buf, tsh, rsh, rx_next;
  logic          sda_s, scl_rise, scl_fall, mst_run, scl_low, sda_rel;

  // named internal events
  logic start_go, bit_fall, frame_end, rx_sample, byte_done, ack_sample, arb_det, data_phase;

  i2cs_linewatch u_watch (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(ev_start), .stop_det(ev_stop)
  );

  i2cs_baud #(.DIV_W(DIV_W), .HP_LAST(HP_LAST)) u_baud (
    .clk(clk), .rst_n(rst_n), .go(start_go & master), .phase(clk_phase),
    .div_n(div_n), .run(mst_run), .scl_low(scl_low)
  );

  i2cs_sdalag u_lag (
    .clk(clk), .rst_n(rst_n), .load(bit_fall), .val(drv), .sel(lag_sel), .rel(sda_rel)
  );

  assign start_go   = tx_en & tx_full & ~active & ~mst_run;
  assign data_phase = bitcnt < CW'(DW);
  assign bit_fall   = active & scl_fall;
  assign frame_end  = bit_fall & (bitcnt == CW'(DW + 1));
  assign rx_sample  = active & scl_rise & (bitcnt <= CW'(DW));
  assign byte_done  = rx_sample & (bitcnt == CW'(DW - 1));
  assign ack_sample = rx_sample & (bitcnt == CW'(DW));
  assign arb_det    = rx_sample & data_phase & ~rx_en & cur_bit & ~sda_s & ~arb_hit;
  assign rx_next    = {rsh[DW-2:0], sda_s};

  // level to present after the next SCL fall (1 = released)
  always_comb begin
    if (data_phase)               drv = arb_hit | tsh[DW-1];
    else if (bitcnt == CW'(DW))   drv = ~rx_en;
    else                          drv = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
    end else if (tx_wr) begin
      tx_buf  <= tx_data;
      tx_full <= 1'b1;
    end else if (start_go) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      bitcnt   <= '0;
      tsh      <= '1;
      rsh      <= '0;
      cur_bit  <= 1'b1;
      arb_hit  <= 1'b0;
      arb_lost <= 1'b0;
    end else if (start_go) begin
      active   <= 1'b1;
      bitcnt   <= '0;
      tsh      <= tx_buf;
      cur_bit  <= 1'b1;
      arb_hit  <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      if (bit_fall) begin
        cur_bit <= drv;
        if (data_phase) tsh <= {tsh[DW-2:0], 1'b1};
        if (frame_end) begin
          active <= 1'b0;
          if (abt_sel && arb_hit) arb_lost <= 1'b1;
        end
      end
      if (rx_sample) begin
        rsh    <= rx_next;
        bitcnt <= bitcnt + 1'b1;
      end
      if (arb_det) begin
        arb_hit <= 1'b1;
        if (!abt_sel) arb_lost <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_done <= 1'b0;
      overrun <= 1'b0;
      ev_ack  <= 1'b0;
      ev_nack <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      ev_ack  <= ack_sample & ~sda_s;
      ev_nack <= ack_sample & sda_s;
      if (byte_done && rx_en) begin
        if (rx_full && !rx_rd) begin
          overrun <= 1'b1;
        end else begin
          rx_data <= rx_next;
          rx_full <= 1'b1;
          rx_done <= 1'b1;
          overrun <= 1'b0;
        end
      end else if (rx_rd) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  assign busy   = active | mst_run;
  assign scl_oe = mst_run & scl_low;
  assign sda_oe = ~sda_rel;
endmodule

// File: rtl/i2cs_checks.sv
module i2cs_checks (
  input logic clk,
  input logic rst_n,
  input logic master,
  input logic tx_en,
  input logic abt_sel,
  input logic scl_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic overrun,
  input logic rx_done,
  input logic arb_lost,
  input logic frame_end,
  input logic ev_start,
  input logic ev_stop,
  input logic ev_ack,
  input logic ev_nack
);
  a_r3_start_needs_tx_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en));

  a_r11_slave_never_pulls_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !scl_oe);

  a_r4_sda_moves_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  a_r7_ack_nack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ack && ev_nack));

  a_r6_start_stop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_start && ev_stop));

  a_r9_overrun_without_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !rx_done);

  a_r10_late_flag_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(arb_lost) && abt_sel) |-> $past(frame_end));
endmodule

bind i2cs_engine i2cs_checks u_chk (
  .clk(clk), .rst_n(rst_n), .master(master), .tx_en(tx_en), .abt_sel(abt_sel),
  .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .overrun(overrun),
  .rx_done(rx_done), .arb_lost(arb_lost), .frame_end(frame_end), .ev_start(ev_start),
  .ev_stop(ev_stop), .ev_ack(ev_ack), .ev_nack(ev_nack)
);

// File: tb/i2cs_engine_tb.sv
module i2cs_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       master = 1'b1, tx_en = 1'b0, rx_en = 1'b0, abt_sel = 1'b0, clk_phase = 1'b0;
  logic [7:0] div_n = 8'd15, tx_data = 8'h00, rx_data;
  logic [2:0] lag_sel = 3'd0;
  logic       tx_wr = 1'b0, rx_rd = 1'b0;
  logic       tx_full, rx_full, rx_done, overrun, arb_lost, busy;
  logic       ev_start, ev_stop, ev_ack, ev_nack, scl_oe, sda_oe;
  logic       tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  wire        scl_line = ~scl_oe & ~tb_scl_low;
  wire        sda_line = ~sda_oe & ~tb_sda_low;

  i2cs_engine u_dut (
    .clk(clk), .rst_n(rst_n), .master(master), .tx_en(tx_en), .rx_en(rx_en),
    .abt_sel(abt_sel), .clk_phase(clk_phase), .div_n(div_n), .lag_sel(lag_sel),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_full(tx_full), .rx_full(rx_full), .rx_done(rx_done), .overrun(overrun),
    .arb_lost(arb_lost), .busy(busy), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_ack(ev_ack), .ev_nack(ev_nack), .scl_in(scl_line), .scl_oe(scl_oe),
    .sda_in(sda_line), .sda_oe(sda_oe)
  );

  int checks = 0, errors = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_ack = 0, n_nack = 0, n_done = 0;
  int t_wr, t_fall1, t_fall2, t_sda;
  logic arb_mid, scl_pulled;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) begin
    if (ev_start) n_start++;
    if (ev_stop)  n_stop++;
    if (ev_ack)   n_ack++;
    if (ev_nack)  n_nack++;
    if (rx_done)  n_done++;
    if (scl_oe)   scl_pulled = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_wr   = 1'b1;
    t_wr    = cyc;
    @(negedge clk);
    tx_wr   = 1'b0;
  endtask

  // far-end model for master frames: pull[7] acts on the first bit
  task automatic slave_frame(input logic [7:0] pull, input logic ack_low,
                             output logic [8:0] seen);
    int   falls = 0, rises = 0;
    logic prev = 1'b1, got = 1'b0;
    seen = '0;
    while (falls < 10) begin
      @(negedge clk);
      if (falls >= 1 && !got && !sda_line) begin got = 1'b1; t_sda = cyc; end
      if (!prev && scl_line) begin
        rises++;
        if (rises <= 9) seen[9 - rises] = sda_line;
      end
      if (prev && !scl_line) begin
        falls++;
        if (falls == 1) t_fall1 = cyc;
        if (falls == 2) t_fall2 = cyc;
        if (falls == 5) arb_mid = arb_lost;
        prev = 1'b0;
        repeat (2) @(negedge clk);
        if (falls <= 8)      tb_sda_low = pull[8 - falls];
        else if (falls == 9) tb_sda_low = ack_low;
        else                 tb_sda_low = 1'b0;
      end
      prev = scl_line;
    end
    while (busy) @(negedge clk);
  endtask

  // bench acting as bus master for slave mode; returns level in the 9th high phase
  task automatic master_drive(input logic [7:0] d, output logic ackv);
    for (int i = 0; i < 9; i++) begin
      tb_scl_low = 1'b1;
      repeat (20) @(negedge clk);
      tb_sda_low = (i < 8) ? ~d[7 - i] : 1'b0;
      repeat (20) @(negedge clk);
      tb_scl_low = 1'b0;
      repeat (20) @(negedge clk);
      if (i == 8) ackv = sda_line;
    end
    tb_scl_low = 1'b1;
    repeat (20) @(negedge clk);
    tb_sda_low = 1'b0;
    repeat (20) @(negedge clk);
    tb_scl_low = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // vector: {div_n, lag_sel, data (msb 0), far end acknowledges}
  localparam logic [19:0] VECS [4] = '{
    {8'd15, 3'd0, 8'h5A, 1'b1},
    {8'd20, 3'd1, 8'h3C, 1'b0},
    {8'd12, 3'd7, 8'h01, 1'b1},
    {8'd30, 3'd4, 8'h7E, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] seen;
    logic       ackv;
    int         d0, d1, a0, nk0, dn0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_oe && !sda_oe && !busy, "R11 reset lines released", {scl_oe, sda_oe, busy}, 0);
    check(!tx_full && !rx_full && !overrun && !arb_lost, "R3 reset flags clear",
          {tx_full, rx_full, overrun, arb_lost}, 0);

    // vector walk: master transmit
    tx_en = 1'b1;
    foreach (VECS[i]) begin
      div_n   = VECS[i][19:12];
      lag_sel = VECS[i][11:9];
      a0 = n_ack; nk0 = n_nack;
      write_tx(VECS[i][8:1]);
      slave_frame(8'h00, VECS[i][0], seen);
      check(seen[8:1] == VECS[i][8:1], "R2 bits on SDA msb first", seen[8:1], VECS[i][8:1]);
      check(t_fall2 - t_fall1 == 2 * (int'(div_n) + 1), "R1 SCL period",
            t_fall2 - t_fall1, 2 * (int'(div_n) + 1));
      check(t_sda - t_fall1 == ((lag_sel == 0) ? 3 : int'(lag_sel) + 4), "R4 SDA lag",
            t_sda - t_fall1, (lag_sel == 0) ? 3 : int'(lag_sel) + 4);
      if (VECS[i][0]) check(n_ack == a0 + 1 && n_nack == nk0, "R7 ack pulse", n_ack - a0, 1);
      else            check(n_nack == nk0 + 1 && n_ack == a0, "R7 nack pulse", n_nack - nk0, 1);
      check(seen[0] == ~VECS[i][0], "R7 ack bit level", seen[0], ~VECS[i][0]);
    end

    // clock phase
    div_n = 8'd15; lag_sel = 3'd0;
    write_tx(8'h11); slave_frame(8'h00, 1'b1, seen); d0 = t_fall1 - t_wr;
    clk_phase = 1'b1;
    write_tx(8'h11); slave_frame(8'h00, 1'b1, seen); d1 = t_fall1 - t_wr;
    clk_phase = 1'b0;
    check(d1 - d0 == 16, "R5 phase stretch", d1 - d0, 16);

    // gating
    tx_en = 1'b0;
    write_tx(8'h66);
    repeat (200) @(negedge clk);
    check(!busy && tx_full && !scl_oe, "R3 no start without tx_en", busy, 0);
    rx_en = 1'b1;
    repeat (200) @(negedge clk);
    check(!busy && tx_full, "R3 rx_en alone starts nothing", busy, 0);
    rx_en = 1'b0; tx_en = 1'b1;
    slave_frame(8'h00, 1'b1, seen);
    check(seen[8:1] == 8'h66 && !tx_full, "R3 start once enabled", seen[8:1], 8'h66);

    // start and stop conditions
    d0 = n_start; d1 = n_stop;
    @(negedge clk); tb_sda_low = 1'b1;
    repeat (6) @(negedge clk);
    check(n_start == d0 + 1 && n_stop == d1, "R6 start pulse", n_start - d0, 1);
    tb_sda_low = 1'b0;
    repeat (6) @(negedge clk);
    check(n_stop == d1 + 1 && n_start == d0 + 1, "R6 stop pulse", n_stop - d1, 1);

    // master receive
    rx_en = 1'b1;
    dn0 = n_done;
    write_tx(8'hFF); slave_frame(~8'hC3, 1'b0, seen);
    check(rx_data == 8'hC3 && rx_full, "R8 byte stored", rx_data, 8'hC3);
    check(n_done == dn0 + 1, "R8 rx_done pulse", n_done - dn0, 1);
    check(seen[0] == 1'b0, "R8 block drives ack low", seen[0], 0);

    // overrun: second byte with no read
    write_tx(8'hFF); slave_frame(~8'h3E, 1'b0, seen);
    check(overrun && rx_full, "R9 overrun set", overrun, 1);
    check(n_done == dn0 + 1, "R9 no rx_done on overrun", n_done - dn0, 1);
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    check(!overrun && !rx_full, "R9 read clears flags", {overrun, rx_full}, 0);

    // read in the completion cycle
    write_tx(8'hFF); slave_frame(~8'h81, 1'b0, seen);
    dn0 = n_done;
    write_tx(8'hFF);
    fork
      slave_frame(~8'h5C, 1'b0, seen);
      begin
        int   r = 0;
        logic p = 1'b1;
        while (r < 8) begin
          @(negedge clk);
          if (!p && scl_line) r++;
          p = scl_line;
        end
        @(negedge clk); @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
      end
    join
    check(!overrun && rx_data == 8'h5C, "R9 read at completion stores byte", rx_data, 8'h5C);
    check(n_done == dn0 + 1 && rx_full, "R9 read at completion pulses", n_done - dn0, 1);
    @(negedge clk); rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    rx_en = 1'b0;

    // arbitration loss, flag at the losing bit
    abt_sel = 1'b0;
    write_tx(8'hF0); slave_frame(8'b0100_0000, 1'b0, seen);
    check(arb_mid == 1'b1, "R10 early flag mid-frame", arb_mid, 1);
    check(seen[4:1] == 4'hF, "R10 SDA released after loss", seen[4:1], 4'hF);
    check(arb_lost, "R10 flag after frame", arb_lost, 1);
    // flag at frame end
    abt_sel = 1'b1;
    write_tx(8'hF0); slave_frame(8'b0100_0000, 1'b0, seen);
    check(arb_mid == 1'b0 && arb_lost, "R10 late flag", {arb_mid, arb_lost}, 1);
    abt_sel = 1'b0;
    write_tx(8'h0F); slave_frame(8'h00, 1'b1, seen);
    check(!arb_lost && seen[8:1] == 8'h0F, "R10 cleared by next frame", arb_lost, 0);

    // slave mode receive
    master = 1'b0; rx_en = 1'b1; lag_sel = 3'd2;
    scl_pulled = 1'b0;
    write_tx(8'hFF);
    repeat (4) @(negedge clk);
    master_drive(8'hA5, ackv);
    check(rx_data == 8'hA5, "R11 slave byte from scl_in", rx_data, 8'hA5);
    check(ackv == 1'b0 && !scl_pulled, "R11 slave acks and never pulls SCL",
          {ackv, scl_pulled}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule